// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the arithmetic and logic engine of an accumulator-style microcontroller datapath. Each operation takes two operands. The first is the working-register value. The second is a byte that the surrounding datapath has already chosen, either an instruction literal or a file-register value. The block returns an 8-bit result and keeps a five-flag status register. It also holds a separate 16-bit product register for unsigned multiplies.

Operations arrive on a valid/ready stream. One operation is accepted on each clock edge where `in_valid` and `in_ready` are both high. Its result is registered and offered on an output stream. Back-pressure works as follows:
- `in_ready` is high whenever the output slot is empty or is being drained in the same cycle.
- While `out_ready` is low, the offered result and the flags are held unchanged.

The status register is updated when an operation is accepted. The next operation therefore sees the carry left by the one before it, including in back-to-back streams.

Top module: `alu8_core`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`.
  - An accepted operation appears on `out_valid`/`out_result`/`out_flags` on the next clock edge.
  - While `out_valid` is high and `out_ready` is low, `out_result`, `out_flags` and `out_prod` are held stable.
- R2: Arithmetic opcodes (W = `in_w`, F = `in_f`):
  - 0 gives F+W.
  - 1 gives F+W+C.
  - 2 gives F−W.
  - 3 gives F−W−(1−C).
  - 4 gives F+1.
  - 5 gives F−1.
  - 6 gives 0−F.
- R3: Every arithmetic opcode writes all five flags in `out_flags`. The bit positions are: bit 4 N, bit 3 OV, bit 2 Z, bit 1 DC, bit 0 C.
  - N is result bit 7.
  - Z is set when the result is zero.
  - OV flags two's-complement overflow.
  - For additions, C is the carry out of bit 7 and DC is the carry out of bit 3.
  - For subtractions (2, 3, 5, 6), C and DC are no-borrow indications, meaning 1 when no borrow occurs.
- R4: Opcodes 1 and 3 take their carry/borrow input from the C flag left by the previously accepted operation.
- R5: Logic opcodes update N and Z only; OV, DC and C are unchanged.
  - 7 gives W AND F.
  - 8 gives W OR F.
  - 9 gives W XOR F.
  - 10 gives NOT F.
- R6: Three further opcodes handle clear, move and set.
  - Opcode 11 (clear) gives 0x00 with Z=1 and N=0.
  - Opcode 13 (move) gives F and updates N and Z only.
  - Opcode 12 (set) gives 0xFF and leaves all flags unchanged.
- R7: Opcodes 14 and 15 are 8-bit rotates, left and right respectively, that wrap the end bit around. They update N and Z only.
- R8: Opcodes 16 and 17 are 9-bit rotates through C, left and right respectively. They update C, N and Z.
  - The bit rotated out goes to C.
  - The old C enters at the opposite end.
- R9: Opcode 18 loads `out_prod` with the unsigned W×F.
  - The flags are unchanged.
  - `out_result` returns W.
  - No other opcode changes `out_prod`.
- R10: After reset, `out_valid`=0, `out_result`=0, `out_flags`=0, `out_prod`=0 and `in_ready`=1.
- R11: Opcodes 19 to 31 pass W to `out_result` and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_op | input | 5 | Opcode |
| in_w | input | 8 | Working-register operand |
| in_f | input | 8 | Literal or file-register operand |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 8 | Registered result byte |
| out_flags | output | 5 | Status register {N, OV, Z, DC, C} |
| out_prod | output | 16 | Product register from the last multiply |

## Verification
Every result, flag and product value is due one clock edge after the edge that accepts the operation. The bench drives each operation at a falling edge and lets the next rising edge accept it. It then compares the outputs at the following falling edge, so each sample sits half a period away from the register update.

During stalls, the bench compares the held outputs at every falling edge while `out_ready` stays low. After release, it checks that `out_valid` drops one edge later. The bench carries its own model of the flags from operation to operation, so the carry-chained opcodes are checked against the C flag the model predicts.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBB = 5'd3,
    OP_INC  = 5'd4,
    OP_DEC  = 5'd5,
    OP_NEG  = 5'd6,
    OP_AND  = 5'd7,
    OP_OR   = 5'd8,
    OP_XOR  = 5'd9,
    OP_COM  = 5'd10,
    OP_CLR  = 5'd11,
    OP_SET  = 5'd12,
    OP_MOV  = 5'd13,
    OP_RL   = 5'd14,
    OP_RR   = 5'd15,
    OP_RLC  = 5'd16,
    OP_RRC  = 5'd17,
    OP_MUL  = 5'd18
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic dc;
    logic c;
  } flags_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e            op,
  input  logic [WIDTH-1:0]   w,
  input  logic [WIDTH-1:0]   f,
  input  logic               cin,
  output logic [WIDTH-1:0]   res,
  output flags_t             fl,
  output logic               hit
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] opa, opb;
  logic             ci;
  logic [HALF:0]    low_sum;
  logic [WIDTH:0]   full_sum;

  // Every arithmetic opcode is mapped onto one adder: a + b + ci.
  // Subtraction uses the inverted subtrahend, so the carry out is a no-borrow bit.
  always_comb begin
    opa = f;
    opb = w;
    ci  = 1'b0;
    hit = 1'b1;
    unique case (op)
      OP_ADD:  begin opb = w;                 ci = 1'b0; end
      OP_ADDC: begin opb = w;                 ci = cin;  end
      OP_SUB:  begin opb = ~w;                ci = 1'b1; end
      OP_SUBB: begin opb = ~w;                ci = cin;  end
      OP_INC:  begin opb = '0;                ci = 1'b1; end
      OP_DEC:  begin opb = '1;                ci = 1'b0; end
      OP_NEG:  begin opa = '0; opb = ~f;      ci = 1'b1; end
      default: hit = 1'b0;
    endcase
  end

  assign low_sum  = {1'b0, opa[HALF-1:0]} + {1'b0, opb[HALF-1:0]} + {{HALF{1'b0}}, ci};
  assign full_sum = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, ci};
  assign res      = full_sum[WIDTH-1:0];

  always_comb begin
    fl.n  = res[WIDTH-1];
    fl.z  = (res == '0);
    fl.c  = full_sum[WIDTH];
    fl.dc = low_sum[HALF];
    fl.ov = (opa[WIDTH-1] == opb[WIDTH-1]) && (res[WIDTH-1] != opa[WIDTH-1]);
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e            op,
  input  logic [WIDTH-1:0]   w,
  input  logic [WIDTH-1:0]   f,
  input  logic               cin,
  output logic [WIDTH-1:0]   res,
  output logic               c_out,
  output logic               upd_nz,
  output logic               upd_c,
  output logic               hit
);
  // Bitwise, constant and rotate operations, with the flag subset each one writes.
  always_comb begin
    res    = f;
    c_out  = cin;
    upd_nz = 1'b1;
    upd_c  = 1'b0;
    hit    = 1'b1;
    unique case (op)
      OP_AND: res = w & f;
      OP_OR:  res = w | f;
      OP_XOR: res = w ^ f;
      OP_COM: res = ~f;
      OP_CLR: res = '0;
      OP_SET: begin res = '1; upd_nz = 1'b0; end
      OP_MOV: res = f;
      OP_RL:  res = {f[WIDTH-2:0], f[WIDTH-1]};
      OP_RR:  res = {f[0], f[WIDTH-1:1]};
      OP_RLC: begin res = {f[WIDTH-2:0], cin}; c_out = f[WIDTH-1]; upd_c = 1'b1; end
      OP_RRC: begin res = {cin, f[WIDTH-1:1]}; c_out = f[0];       upd_c = 1'b1; end
      default: begin hit = 1'b0; upd_nz = 1'b0; end
    endcase
  end

endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   w,
  input  logic [WIDTH-1:0]   f,
  output logic [2*WIDTH-1:0] prod
);
  localparam int PW = 2 * WIDTH;

  // Shift-and-add array: one partial product per multiplier bit.
  logic [PW-1:0] partial [WIDTH];
  logic [PW-1:0] acc     [WIDTH+1];

  assign acc[0] = '0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_row
    assign partial[i] = f[i] ? ({{WIDTH{1'b0}}, w} << i) : '0;
    assign acc[i+1]   = acc[i] + partial[i];
  end

  assign prod = acc[WIDTH];

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [4:0]         in_op,
  input  logic [WIDTH-1:0]   in_w,
  input  logic [WIDTH-1:0]   in_f,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WIDTH-1:0]   out_result,
  output logic [4:0]         out_flags,
  output logic [2*WIDTH-1:0] out_prod
);
  localparam int PW = 2 * WIDTH;

  alu_op_e          op_e;
  flags_t           flags_q, flags_n;
  logic [WIDTH-1:0] res_q, res_n;
  logic [PW-1:0]    prod_q, m_prod;
  logic             valid_q, acc;

  logic [WIDTH-1:0] a_res, l_res;
  flags_t           a_fl;
  logic             a_hit, l_hit, l_c, l_nz, l_uc;

  assign op_e = alu_op_e'(in_op);

  alu8_arith #(.WIDTH(WIDTH)) u_arith (
    .op(op_e), .w(in_w), .f(in_f), .cin(flags_q.c),
    .res(a_res), .fl(a_fl), .hit(a_hit)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .op(op_e), .w(in_w), .f(in_f), .cin(flags_q.c),
    .res(l_res), .c_out(l_c), .upd_nz(l_nz), .upd_c(l_uc), .hit(l_hit)
  );

  alu8_mul #(.WIDTH(WIDTH)) u_mul (
    .w(in_w), .f(in_f), .prod(m_prod)
  );

  // Result and flag merge: each class writes only its own flag subset.
  always_comb begin
    flags_n = flags_q;
    res_n   = in_w;
    if (a_hit) begin
      res_n   = a_res;
      flags_n = a_fl;
    end else if (l_hit) begin
      res_n = l_res;
      if (l_nz) begin
        flags_n.n = l_res[WIDTH-1];
        flags_n.z = (l_res == '0);
      end
      if (l_uc) flags_n.c = l_c;
    end
  end

  assign in_ready = !valid_q || out_ready;
  assign acc      = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      flags_q <= '0;
      prod_q  <= '0;
    end else begin
      if (acc) begin
        valid_q <= 1'b1;
        res_q   <= res_n;
        flags_q <= flags_n;
        if (op_e == OP_MUL) prod_q <= m_prod;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_result = res_q;
  assign out_flags  = flags_q;
  assign out_prod   = prod_q;

  // R1: a stalled result is held
  a_r1_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags) && $stable(out_prod)));

  // R1: an accepted operation is offered on the next edge
  a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R3: arithmetic N and Z follow the registered result
  a_r3_nz_arith: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && a_hit) |=> ((out_flags[2] == (out_result == '0)) && (out_flags[4] == out_result[WIDTH-1])));

  // R5: logic opcodes keep OV, DC and C
  a_r5_logic_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op_e inside {OP_AND, OP_OR, OP_XOR, OP_COM})) |=>
      (out_flags[3] == $past(out_flags[3]) && out_flags[1:0] == $past(out_flags[1:0])));

  // R6: clear yields zero with Z set
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_e == OP_CLR) |=> (out_result == '0 && out_flags[2] && !out_flags[4]));

  // R7: plain rotates leave C untouched
  a_r7_rot_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op_e inside {OP_RL, OP_RR})) |=> (out_flags[0] == $past(out_flags[0])));

  // R9: multiply leaves the flags alone
  a_r9_mul_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_e == OP_MUL) |=> $stable(out_flags));

endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = '0;
  logic [7:0]  in_w = '0;
  logic [7:0]  in_f = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_result;
  logic [4:0]  out_flags;
  logic [15:0] out_prod;

  int  n_tests = 0;
  int  n_fail  = 0;
  logic [4:0]  m_flags = '0;
  logic [15:0] m_prod  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core i_alu8_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_w(in_w), .in_f(in_f), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_flags(out_flags),
    .out_prod(out_prod)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int sx(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // {result, N, OV, Z, DC, C} for a + b + k (sub=0) or a - b - k (sub=1)
  function automatic logic [12:0] arith(int a, int b, int k, bit sub);
    int s, sv, r;
    bit c, dc, ov;
    if (!sub) begin
      s  = a + b + k;
      c  = (s > 255);
      dc = ((a % 16) + (b % 16) + k) > 15;
      sv = sx(a) + sx(b) + k;
    end else begin
      s  = a - b - k;
      c  = (s >= 0);
      dc = ((a % 16) - (b % 16) - k) >= 0;
      sv = sx(a) - sx(b) - k;
    end
    ov = (sv > 127) || (sv < -128);
    r  = (s + 512) % 256;
    return {r[7:0], r[7], ov, (r == 0), dc, c};
  endfunction

  function automatic logic [12:0] model(int op, logic [7:0] w, logic [7:0] f, logic [4:0] fl);
    logic [7:0] r;
    logic [4:0] nf;
    int cc;
    cc = int'(fl[0]);
    nf = fl;
    r  = w;
    case (op)
      0:  return arith(f, w, 0, 1'b0);
      1:  return arith(f, w, cc, 1'b0);
      2:  return arith(f, w, 0, 1'b1);
      3:  return arith(f, w, 1 - cc, 1'b1);
      4:  return arith(f, 1, 0, 1'b0);
      5:  return arith(f, 1, 0, 1'b1);
      6:  return arith(0, f, 0, 1'b1);
      7:  r = w & f;
      8:  r = w | f;
      9:  r = w ^ f;
      10: r = ~f;
      11: r = 8'h00;
      12: r = 8'hFF;
      13: r = f;
      14: r = {f[6:0], f[7]};
      15: r = {f[0], f[7:1]};
      16: begin r = {f[6:0], fl[0]}; nf[0] = f[7]; end
      17: begin r = {fl[0], f[7:1]}; nf[0] = f[0]; end
      default: r = w;
    endcase
    if (op >= 7 && op <= 17 && op != 12) begin
      nf[4] = r[7];
      nf[2] = (r == 8'h00);
    end
    return {r, nf};
  endfunction

  function automatic string tag(int op);
    if (op <= 6)  return "R3";
    if (op <= 10) return "R5";
    if (op <= 13) return "R6";
    if (op <= 15) return "R7";
    if (op <= 17) return "R8";
    if (op == 18) return "R9";
    return "R11";
  endfunction

  // Drive at a falling edge, accepted at the next rising edge, checked at the falling edge after.
  task automatic do_op(int op, logic [7:0] w, logic [7:0] f);
    logic [12:0] e;
    e = model(op, w, f, m_flags);
    in_op = op[4:0]; in_w = w; in_f = f; in_valid = 1'b1;
    check("R1", "in_ready before accept", 32'(in_ready), 32'd1);
    @(posedge clk);
    m_flags = e[4:0];
    if (op == 18) m_prod = 16'(w) * 16'(f);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", "out_valid", 32'(out_valid), 32'd1);
    check(tag(op), $sformatf("result op%0d", op), 32'(out_result), 32'(e[12:5]));
    check(tag(op), $sformatf("flags op%0d", op), 32'(out_flags), 32'(e[4:0]));
    check("R9", "prod", 32'(out_prod), 32'(m_prod));
  endtask

  task automatic stall_op(int op, logic [7:0] w, logic [7:0] f, int hold);
    logic [12:0] e;
    e = model(op, w, f, m_flags);
    in_op = op[4:0]; in_w = w; in_f = f; in_valid = 1'b1;
    @(posedge clk);
    m_flags = e[4:0];
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R1", "stalled valid", 32'(out_valid), 32'd1);
      check("R1", "stalled in_ready", 32'(in_ready), 32'd0);
      check("R1", "stalled result", 32'(out_result), 32'(e[12:5]));
      check("R1", "stalled flags", 32'(out_flags), 32'(e[4:0]));
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R1", "valid after drain", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "out_valid", 32'(out_valid), 32'd0);
    check("R10", "out_result", 32'(out_result), 32'd0);
    check("R10", "out_flags", 32'(out_flags), 32'd0);
    check("R10", "out_prod", 32'(out_prod), 32'd0);
    check("R10", "in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners: R2 R3 carries, nibble carries, overflow
    do_op(0, 8'h92, 8'h37);
    do_op(0, 8'h01, 8'hFF);     // carry out and zero
    do_op(0, 8'h01, 8'h7F);     // signed overflow
    do_op(0, 8'h08, 8'h08);     // nibble carry only
    do_op(1, 8'h00, 8'h00);     // R4 uses C=0 left by previous
    do_op(0, 8'h80, 8'h80);     // sets C
    do_op(1, 8'h00, 8'h00);     // R4 C=1 adds one
    do_op(2, 8'h05, 8'h03);     // borrow: C=0
    do_op(3, 8'h01, 8'h05);     // R4 borrow consumed
    do_op(2, 8'h05, 8'h05);     // zero, no borrow
    do_op(3, 8'h01, 8'h05);     // R4 C=1 no extra borrow
    do_op(2, 8'h01, 8'h80);     // overflow on subtraction
    do_op(4, 8'h00, 8'hFF);     // increment wraps
    do_op(4, 8'h00, 8'h7F);
    do_op(5, 8'h00, 8'h00);     // decrement borrows
    do_op(5, 8'h00, 8'h80);
    do_op(6, 8'h00, 8'h00);     // negate zero
    do_op(6, 8'h00, 8'h80);
    do_op(6, 8'h00, 8'h01);
    // R5 logic keeps C/DC/OV from a previous arith
    do_op(0, 8'hFF, 8'h89);
    do_op(7, 8'hF0, 8'h0F);
    do_op(8, 8'h80, 8'h01);
    do_op(9, 8'hAA, 8'hAA);
    do_op(10, 8'h00, 8'h00);
    // R6
    do_op(11, 8'h12, 8'h34);
    do_op(12, 8'h12, 8'h34);
    do_op(13, 8'h12, 8'h80);
    do_op(13, 8'h12, 8'h00);
    // R7 R8 rotates
    do_op(14, 8'h00, 8'h81);
    do_op(15, 8'h00, 8'h01);
    do_op(16, 8'h00, 8'h80);
    do_op(16, 8'h00, 8'h00);
    do_op(17, 8'h00, 8'h01);
    do_op(17, 8'h00, 8'h00);
    // R9 multiply
    do_op(18, 8'hFF, 8'hFF);
    do_op(13, 8'h00, 8'h55);    // prod must hold
    do_op(18, 8'h12, 8'h00);
    // R11 unused codes
    do_op(19, 8'hA5, 8'h3C);
    do_op(31, 8'h00, 8'hFF);
    // R1 back-pressure
    stall_op(0, 8'h40, 8'h40, 4);
    stall_op(16, 8'h00, 8'hC3, 2);

    // Random stream
    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom % 24);
      do_op(op, 8'($urandom), 8'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule